// File: doc/BRIEF.md
# Banked Register File for a 16/32-bit Core

This block stores the programmer-visible working registers of a small 16/32-bit processor core. Each of two banks holds four 16-bit data registers and four 24-bit pointer registers (two address registers, a static base and a frame base). A bank-select input chooses which bank every read and write reaches. A pair of 24-bit stack pointers sits outside the banks. A stack-select input chooses which of the two a stack access reaches.

The two lower data registers can be reached a byte at a time. Any data register can be reached as a 16-bit word. The two lower data registers also serve as the low halves of 32-bit pairs, with the two upper data registers as the high halves. The core's decode stage supplies a register code, an access size and a half-select. The file returns data zero-extended to 32 bits on two independent combinational read ports. It accepts one write per clock on a single write port.

Register codes: 0 to 3 name data registers D0 to D3, 4 and 5 the address registers, 6 the static base, 7 the frame base, and 8 the active stack pointer. Codes 9 to 15 are unused. Size codes: 0 is byte, 1 is word, 2 is pair, and 3 behaves as word.

Top module: `cpu_regfile`

## Requirements
- R1: While reset is asserted, and after it is released, every register of both banks and both stack pointers reads as zero.
- R2: A word access (size 1 or 3) to D0 to D3 reads or writes the full 16 bits. A non-byte access to codes 4 to 8 writes bits 23:0 of the write data, and reads return the 24-bit value zero-extended.
- R3: A byte access (size 0) to D0 or D1 uses bits 7:0 when the half-select is 0 and bits 15:8 when it is 1. Read data is zero-extended, and write data is taken from bits 7:0.
- R4: A byte write changes only the addressed half. The other half of that register keeps its value.
- R5: A pair access (size 2) to code 0 reaches {D2,D0}, and to code 1 reaches {D3,D1}, with the upper register in bits 31:16. A pair write updates both registers on the same clock edge. A pair access to codes 2 to 8 behaves as a word access.
- R6: Bank select 0 directs every read and write to bank 0, and 1 directs them to bank 1. A write never changes the bank that is not selected.
- R7: Stack select 0 makes code 8 reach the interrupt stack pointer, and 1 makes it reach the user stack pointer. The stack pointers do not follow the bank select, and a write never changes the stack pointer that is not selected.
- R8: Reads are combinational. A write becomes visible on the clock edge that takes it, so a read of the written register in the same cycle returns the old value.
- R9: A byte access to codes 2 to 15, and any access to codes 9 to 15, writes nothing and reads zero.
- R10: The two read ports decode their register code, size and half-select independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bank_sel | input | 1 | Bank select for reads and writes |
| stk_sel | input | 1 | Stack pointer select: 0 interrupt, 1 user |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 4 | Write register code |
| wr_size | input | 2 | Write access size code |
| wr_hi | input | 1 | Write byte half-select |
| wr_data | input | 32 | Write data |
| ra_sel | input | 4 | Read port A register code |
| ra_size | input | 2 | Read port A size code |
| ra_hi | input | 1 | Read port A byte half-select |
| ra_data | output | 32 | Read port A data |
| rb_sel | input | 4 | Read port B register code |
| rb_size | input | 2 | Read port B size code |
| rb_hi | input | 1 | Read port B byte half-select |
| rb_data | output | 32 | Read port B data |

## Verification
The checker watches every cycle for the properties that concern the state itself. It checks that reset holds every register at zero, that a byte write leaves the other half alone, and that a pair write lands in both registers on one edge. It also checks that the bank and stack pointer that are not selected never move, that ignored byte writes leave all state untouched, and that a word read of D0 follows the stored value combinationally. Other behaviour shows only in the bench's scenarios, run against an independent model: the full decode of sizes and half-selects on both read ports, the zero-extension rules, old-value reads in the cycle of a write, and long random mixes of bank and stack switching.

// File: rtl/cpu_regfile_pkg.sv
package cpu_regfile_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_PAIR = 2'd2,
    SZ_ALTW = 2'd3
  } acc_size_e;
endpackage

// File: rtl/regfile_wdec.sv
module regfile_wdec
  import cpu_regfile_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 24,
  parameter int ND = 4,
  parameter int NA = 4
) (
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [1:0]         wr_size,
  input  logic               wr_hi,
  input  logic [2*DW-1:0]    wr_data,
  output logic [ND-1:0]      d_we_lo,
  output logic [ND-1:0]      d_we_hi,
  output logic [ND*DW-1:0]   d_wd,
  output logic [NA-1:0]      a_we,
  output logic [AW-1:0]      a_wd,
  output logic               sp_we
);
  localparam int BW    = DW / 2;
  localparam int NHALF = ND / 2;

  acc_size_e sz;
  logic      is_byte;
  logic      is_pair;

  assign sz      = acc_size_e'(wr_size);
  assign is_byte = (sz == SZ_BYTE);
  assign is_pair = (sz == SZ_PAIR);
  assign a_wd    = wr_data[AW-1:0];

  always_comb begin
    d_we_lo = '0;
    d_we_hi = '0;
    d_wd    = '0;
    a_we    = '0;
    sp_we   = 1'b0;
    if (wr_en) begin
      for (int i = 0; i < ND; i++) begin
        if (wr_sel == SEL_W'(i)) begin
          if (is_byte) begin
            if (i < NHALF) begin
              d_we_lo[i] = !wr_hi;
              d_we_hi[i] = wr_hi;
              d_wd[i*DW +: DW] = {wr_data[BW-1:0], wr_data[BW-1:0]};
            end
          end else if (is_pair && (i < NHALF)) begin
            d_we_lo[i] = 1'b1;
            d_we_hi[i] = 1'b1;
            d_we_lo[i+NHALF] = 1'b1;
            d_we_hi[i+NHALF] = 1'b1;
            d_wd[i*DW +: DW] = wr_data[DW-1:0];
            d_wd[(i+NHALF)*DW +: DW] = wr_data[2*DW-1:DW];
          end else begin
            d_we_lo[i] = 1'b1;
            d_we_hi[i] = 1'b1;
            d_wd[i*DW +: DW] = wr_data[DW-1:0];
          end
        end
      end
      for (int j = 0; j < NA; j++) begin
        if ((wr_sel == SEL_W'(ND + j)) && !is_byte) a_we[j] = 1'b1;
      end
      if ((wr_sel == SEL_W'(ND + NA)) && !is_byte) sp_we = 1'b1;
    end
  end
endmodule

// File: rtl/regfile_bank.sv
module regfile_bank #(
  parameter int DW = 16,
  parameter int AW = 24,
  parameter int ND = 4,
  parameter int NA = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_en,
  input  logic [ND-1:0]     d_we_lo,
  input  logic [ND-1:0]     d_we_hi,
  input  logic [ND*DW-1:0]  d_wd,
  input  logic [NA-1:0]     a_we,
  input  logic [AW-1:0]     a_wd,
  output logic [ND*DW-1:0]  d_q,
  output logic [NA*AW-1:0]  a_q
);
  localparam int BW = DW / 2;

  logic [ND*DW-1:0] d_r, d_nxt;
  logic [NA*AW-1:0] a_r, a_nxt;
  logic             d_ce, a_ce;

  assign d_ce = bank_en && ((|d_we_lo) || (|d_we_hi));
  assign a_ce = bank_en && (|a_we);

  always_comb begin
    d_nxt = d_r;
    for (int i = 0; i < ND; i++) begin
      if (d_we_lo[i]) d_nxt[i*DW +: BW]      = d_wd[i*DW +: BW];
      if (d_we_hi[i]) d_nxt[i*DW + BW +: BW] = d_wd[i*DW + BW +: BW];
    end
  end

  always_comb begin
    a_nxt = a_r;
    for (int j = 0; j < NA; j++) begin
      if (a_we[j]) a_nxt[j*AW +: AW] = a_wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    d_r <= '0;
    else if (d_ce) d_r <= d_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    a_r <= '0;
    else if (a_ce) a_r <= a_nxt;
  end

  assign d_q = d_r;
  assign a_q = a_r;
endmodule

// File: rtl/regfile_rdport.sv
module regfile_rdport
  import cpu_regfile_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 24,
  parameter int ND = 4,
  parameter int NA = 4
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [1:0]        size,
  input  logic              hi,
  input  logic [ND*DW-1:0]  d_q,
  input  logic [NA*AW-1:0]  a_q,
  input  logic [AW-1:0]     sp_q,
  output logic [2*DW-1:0]   rdata
);
  localparam int BW    = DW / 2;
  localparam int RW    = 2 * DW;
  localparam int NHALF = ND / 2;

  acc_size_e sz;
  assign sz = acc_size_e'(size);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < ND; i++) begin
      if (sel == SEL_W'(i)) begin
        if (sz == SZ_BYTE) begin
          if (i < NHALF) rdata = RW'(hi ? d_q[i*DW + BW +: BW] : d_q[i*DW +: BW]);
        end else if ((sz == SZ_PAIR) && (i < NHALF)) begin
          rdata = {d_q[(i+NHALF)*DW +: DW], d_q[i*DW +: DW]};
        end else begin
          rdata = RW'(d_q[i*DW +: DW]);
        end
      end
    end
    for (int j = 0; j < NA; j++) begin
      if ((sel == SEL_W'(ND + j)) && (sz != SZ_BYTE)) rdata = RW'(a_q[j*AW +: AW]);
    end
    if ((sel == SEL_W'(ND + NA)) && (sz != SZ_BYTE)) rdata = RW'(sp_q);
  end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import cpu_regfile_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 24,
  parameter int ND = 4,
  parameter int NA = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_sel,
  input  logic              stk_sel,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [1:0]        wr_size,
  input  logic              wr_hi,
  input  logic [2*DW-1:0]   wr_data,
  input  logic [SEL_W-1:0]  ra_sel,
  input  logic [1:0]        ra_size,
  input  logic              ra_hi,
  output logic [2*DW-1:0]   ra_data,
  input  logic [SEL_W-1:0]  rb_sel,
  input  logic [1:0]        rb_size,
  input  logic              rb_hi,
  output logic [2*DW-1:0]   rb_data
);
  localparam int NBANK = 2;
  localparam int NSP   = 2;

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic [ND-1:0]    d_we_lo, d_we_hi;
  logic [ND*DW-1:0] d_wd;
  logic [NA-1:0]    a_we;
  logic [AW-1:0]    a_wd;
  logic             sp_we;
  logic [ND*DW-1:0] bank_d [NBANK];
  logic [NA*AW-1:0] bank_a [NBANK];
  logic [AW-1:0]    sp_r   [NSP];
  logic [ND*DW-1:0] cur_d;
  logic [NA*AW-1:0] cur_a;
  logic [AW-1:0]    cur_sp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  regfile_wdec #(.DW(DW), .AW(AW), .ND(ND), .NA(NA)) wdec_i (
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size), .wr_hi(wr_hi),
    .wr_data(wr_data), .d_we_lo(d_we_lo), .d_we_hi(d_we_hi), .d_wd(d_wd),
    .a_we(a_we), .a_wd(a_wd), .sp_we(sp_we)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    regfile_bank #(.DW(DW), .AW(AW), .ND(ND), .NA(NA)) bank_i (
      .clk(clk), .rst_n(rst_int_n), .bank_en(bank_sel == 1'(b)),
      .d_we_lo(d_we_lo), .d_we_hi(d_we_hi), .d_wd(d_wd),
      .a_we(a_we), .a_wd(a_wd), .d_q(bank_d[b]), .a_q(bank_a[b])
    );
  end

  for (genvar s = 0; s < NSP; s++) begin : g_sp
    logic          sp_ce;
    logic [AW-1:0] sp_nxt;
    assign sp_ce = sp_we && (stk_sel == 1'(s));
    always_comb sp_nxt = a_wd;
    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) sp_r[s] <= '0;
      else if (sp_ce) sp_r[s] <= sp_nxt;
    end
  end

  assign cur_d  = bank_d[bank_sel];
  assign cur_a  = bank_a[bank_sel];
  assign cur_sp = sp_r[stk_sel];

  regfile_rdport #(.DW(DW), .AW(AW), .ND(ND), .NA(NA)) rda_i (
    .sel(ra_sel), .size(ra_size), .hi(ra_hi),
    .d_q(cur_d), .a_q(cur_a), .sp_q(cur_sp), .rdata(ra_data)
  );

  regfile_rdport #(.DW(DW), .AW(AW), .ND(ND), .NA(NA)) rdb_i (
    .sel(rb_sel), .size(rb_size), .hi(rb_hi),
    .d_q(cur_d), .a_q(cur_a), .sp_q(cur_sp), .rdata(rb_data)
  );
endmodule

// File: rtl/cpu_regfile_chk.sv
module cpu_regfile_chk
  import cpu_regfile_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 24,
  parameter int ND = 4,
  parameter int NA = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bank_sel,
  input logic              stk_sel,
  input logic              wr_en,
  input logic [SEL_W-1:0]  wr_sel,
  input logic [1:0]        wr_size,
  input logic              wr_hi,
  input logic [2*DW-1:0]   wr_data,
  input logic [SEL_W-1:0]  ra_sel,
  input logic [1:0]        ra_size,
  input logic [2*DW-1:0]   ra_data,
  input logic [ND*DW-1:0]  bd0,
  input logic [ND*DW-1:0]  bd1,
  input logic [NA*AW-1:0]  ba0,
  input logic [NA*AW-1:0]  ba1,
  input logic [AW-1:0]     sp_i,
  input logic [AW-1:0]     sp_u
);
  localparam int BW = DW / 2;
  localparam int PH = (ND / 2) * DW;

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (bd0 == '0 && bd1 == '0 && ba0 == '0 &&
                                     ba1 == '0 && sp_i == '0 && sp_u == '0);
    end
  end

  assert_byte_lo_keeps_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'd0 && wr_sel == 4'd0 && !wr_hi && !bank_sel)
    |=> $stable(bd0[DW-1:BW]));

  assert_byte_hi_keeps_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'd0 && wr_sel == 4'd1 && wr_hi && bank_sel)
    |=> $stable(bd1[DW+BW-1:DW]));

  assert_pair_same_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'd2 && wr_sel == 4'd0 && !bank_sel)
    |=> (bd0[DW-1:0] == $past(wr_data[DW-1:0]) &&
         bd0[PH+DW-1:PH] == $past(wr_data[2*DW-1:DW])));

  assert_other_bank1_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bank_sel) |=> ($stable(bd1) && $stable(ba1)));

  assert_other_bank0_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bank_sel) |=> ($stable(bd0) && $stable(ba0)));

  assert_user_sp_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !stk_sel) |=> $stable(sp_u));

  assert_intr_sp_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && stk_sel) |=> $stable(sp_i));

  assert_comb_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_sel == 4'd0 && ra_size == 2'd1 && !bank_sel)
    |-> (ra_data == {{DW{1'b0}}, bd0[DW-1:0]}));

  assert_byte_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'd0 && wr_sel >= 4'd2)
    |=> ($stable(bd0) && $stable(bd1) && $stable(ba0) && $stable(ba1) &&
         $stable(sp_i) && $stable(sp_u)));
endmodule

bind cpu_regfile cpu_regfile_chk #(.DW(DW), .AW(AW), .ND(ND), .NA(NA)) chk_i (
  .clk(clk), .rst_n(rst_int_n), .bank_sel(bank_sel), .stk_sel(stk_sel),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size), .wr_hi(wr_hi),
  .wr_data(wr_data), .ra_sel(ra_sel), .ra_size(ra_size), .ra_data(ra_data),
  .bd0(bank_d[0]), .bd1(bank_d[1]), .ba0(bank_a[0]), .ba1(bank_a[1]),
  .sp_i(sp_r[0]), .sp_u(sp_r[1])
);

// File: tb/cpu_regfile_tb.sv
module cpu_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bank_sel, stk_sel, wr_en, wr_hi, ra_hi, rb_hi;
  logic [3:0]  wr_sel, ra_sel, rb_sel;
  logic [1:0]  wr_size, ra_size, rb_size;
  logic [31:0] wr_data, ra_data, rb_data;

  logic [15:0] md [2][4];
  logic [23:0] ma [2][4];
  logic [23:0] msp [2];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cpu_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .stk_sel(stk_sel),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size), .wr_hi(wr_hi),
    .wr_data(wr_data), .ra_sel(ra_sel), .ra_size(ra_size), .ra_hi(ra_hi),
    .ra_data(ra_data), .rb_sel(rb_sel), .rb_size(rb_size), .rb_hi(rb_hi),
    .rb_data(rb_data)
  );

  function automatic logic [31:0] exp_read(logic [3:0] s, logic [1:0] z, logic h);
    logic [15:0] d;
    if (s < 4) begin
      d = md[bank_sel][s];
      if (z == 2'd0) return (s < 2) ? (h ? {24'd0, d[15:8]} : {24'd0, d[7:0]}) : 32'd0;
      if (z == 2'd2 && s < 2) return {md[bank_sel][s+2], d};
      return {16'd0, d};
    end
    if (z == 2'd0) return 32'd0;
    if (s < 8) return {8'd0, ma[bank_sel][s-4]};
    if (s == 8) return {8'd0, msp[stk_sel]};
    return 32'd0;
  endfunction

  task automatic model_write();
    if (!wr_en) return;
    if (wr_sel < 4) begin
      if (wr_size == 2'd0) begin
        if (wr_sel < 2) begin
          if (wr_hi) md[bank_sel][wr_sel][15:8] = wr_data[7:0];
          else       md[bank_sel][wr_sel][7:0]  = wr_data[7:0];
        end
      end else if (wr_size == 2'd2 && wr_sel < 2) begin
        md[bank_sel][wr_sel]   = wr_data[15:0];
        md[bank_sel][wr_sel+2] = wr_data[31:16];
      end else md[bank_sel][wr_sel] = wr_data[15:0];
    end else if (wr_size != 2'd0) begin
      if (wr_sel < 8)       ma[bank_sel][wr_sel-4] = wr_data[23:0];
      else if (wr_sel == 8) msp[stk_sel] = wr_data[23:0];
    end
  endtask

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // Called just after a falling edge with inputs set; checks reads, then takes the edge.
  task automatic tick(string req);
    #1;
    check(req, ra_data, exp_read(ra_sel, ra_size, ra_hi));
    check(req, rb_data, exp_read(rb_sel, rb_size, rb_hi));
    @(posedge clk);
    model_write();
    @(negedge clk);
  endtask

  task automatic wr(logic [3:0] s, logic [1:0] z, logic h, logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_size = z; wr_hi = h; wr_data = d;
  endtask

  task automatic rd(logic [3:0] sa, logic [1:0] za, logic ha,
                    logic [3:0] sb, logic [1:0] zb, logic hb);
    ra_sel = sa; ra_size = za; ra_hi = ha; rb_sel = sb; rb_size = zb; rb_hi = hb;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 4; i++) begin md[b][i] = '0; ma[b][i] = '0; end
      msp[b] = '0;
    end
    rst_n = 0; bank_sel = 0; stk_sel = 0; wr_en = 0; wr_sel = 0; wr_size = 1;
    wr_hi = 0; wr_data = 0; rd(0, 1, 0, 0, 1, 0);
    repeat (3) @(negedge clk);
    #1 check("R1 during reset", ra_data, 32'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: every code, both banks, both stack pointers read zero
    for (int b = 0; b < 2; b++) begin
      bank_sel = 1'(b); stk_sel = 1'(b);
      for (int s = 0; s < 9; s++) begin rd(4'(s), 1, 0, 4'(s), 2, 0); tick("R1"); end
    end

    // R2/R8: word write to D2 bank 0, read same cycle gives old value, then new
    bank_sel = 0; stk_sel = 0;
    wr(2, 1, 0, 32'hFFFF_BEEF); rd(2, 1, 0, 2, 3, 0); tick("R8 old value");
    wr_en = 0; tick("R2 word D2");
    check("R8 new value", ra_data, 32'h0000_BEEF);

    // R3/R4: byte writes on D0 halves
    wr(0, 1, 0, 32'h1234); rd(0, 0, 1, 0, 0, 0); tick("R2 word D0");
    wr(0, 0, 1, 32'h00AB); tick("R3 before hi byte");
    wr(0, 0, 0, 32'h00CD); tick("R4 after hi byte");
    wr_en = 0; rd(0, 1, 0, 0, 0, 1); tick("R4 both halves");
    check("R4 D0 word", ra_data, 32'h0000_ABCD);

    // R5: pair write through code 1, bank 1
    bank_sel = 1;
    wr(1, 2, 0, 32'hCAFE_F00D); rd(1, 2, 0, 3, 1, 0); tick("R5 pre");
    wr_en = 0; tick("R5 pair");
    check("R5 pair read", ra_data, 32'hCAFE_F00D);
    check("R5 upper reg", rb_data, 32'h0000_CAFE);

    // R6: bank 0 untouched by bank 1 writes
    bank_sel = 0; rd(1, 2, 0, 3, 1, 0); tick("R6 bank0 untouched");
    check("R6 bank0 pair", ra_data, 32'd0);

    // R7: stack pointers
    stk_sel = 1; wr(8, 1, 0, 32'hFF12_3456); rd(8, 1, 0, 8, 2, 0); tick("R7 pre");
    wr_en = 0; bank_sel = 1; tick("R7 user sp across banks");
    check("R7 user sp", ra_data, 32'h0012_3456);
    stk_sel = 0; tick("R7 intr sp");
    check("R7 intr sp zero", ra_data, 32'd0);

    // R9: byte writes to pointer, D2, unused code ignored
    bank_sel = 0;
    wr(4, 0, 0, 32'h55); rd(4, 1, 0, 2, 0, 1); tick("R9 pre");
    wr(2, 0, 1, 32'h77); tick("R9 pre2");
    wr(12, 1, 0, 32'h99); rd(4, 1, 0, 12, 1, 0); tick("R9 pre3");
    wr_en = 0; rd(4, 1, 0, 2, 1, 0); tick("R9 after");
    check("R9 A0 unchanged", ra_data, 32'd0);
    check("R9 D2 unchanged", rb_data, 32'h0000_BEEF);

    // Random mix: R2 R3 R5 R6 R7 R10 checked against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] s;
      s = 4'($urandom_range(0, 10)); if (s == 4'd10) s = 4'd15;
      bank_sel = 1'($urandom_range(0, 1)); stk_sel = 1'($urandom_range(0, 1));
      wr($urandom_range(0, 3) != 0 ? s : 4'(s ^ 4'd1), 2'($urandom_range(0, 3)),
         1'($urandom_range(0, 1)), $urandom());
      wr_en = 1'($urandom_range(0, 1));
      rd(4'($urandom_range(0, 9)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
         4'($urandom_range(0, 9)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
      tick("R10 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule